// File: doc/BRIEF.md
# Hamming-Protected Word Memory with Split Write Guard

This block is a synchronous word memory in which every stored word is accompanied by Hamming check bits. Each write computes the check bits. Each read recomputes the syndrome and repairs any single flipped bit before the word reaches the output register. The repair exists only on the read path. The array keeps whatever it holds until a new write replaces it. A bypass input returns the stored word exactly as held, while the error indication keeps running.

An access cycle opens when the clock finds chip select newly high. At that clock the address and the write-enable level are captured, and later changes to them are ignored for the rest of the cycle. A write cycle then waits for a separate write-start input before it commits the data. The address space is split into a lower and an upper half, and each half has its own active-low write-inhibit input. Either half can therefore act as writable storage or as read-only storage. A back-door fault port flips one codeword bit in the array. The bench uses it to exercise the correction path.

Top module: `hamming_guarded_ram`

## Requirements
- R1: Each write stores the 16-bit word as a 21-bit Hamming codeword. Codeword positions are numbered 1 to 21, with position p held in array bit p-1. Check bits sit at positions 1, 2, 4, 8 and 16. Data bits fill the other positions in ascending order, with data bit 0 at position 3 and data bit 15 at position 21.
- R2: A read of a word with one flipped data position returns the written word on `data_out` and raises `err_flag`.
- R3: A read of a word with one flipped check-bit position returns the written word unchanged and raises `err_flag`. A word with no fault reads back with `err_flag` low.
- R4: Correction is never written back. A corrected word still flags an error on every later read until a new write replaces it, and after that write it reads clean.
- R5: While `ecc_bypass` is high, `data_out` carries the stored data bits without repair, and `err_flag` still reports a nonzero syndrome.
- R6: A cycle starts at the first clock where `cs` is high after being low. `addr` and `we` are captured at that clock. Changes to them later in the same cycle have no effect, and a cycle captured as a read never writes.
- R7: With `inh_lo_n` low, a write to an address whose top bit is 0 is dropped and the stored word is kept. With `inh_lo_n` high, such a write succeeds.
- R8: `inh_hi_n` guards addresses whose top bit is 1 in the same way, independently of `inh_lo_n`.
- R9: `data_oe` is high only while `cs` and `oe` are high in a read cycle whose data is valid. It is never high in a write cycle or while deselected.
- R10: A captured write commits at the first clock in the cycle where `we_async` is high, taking `data_in` from that clock. It commits at most once per cycle. If `cs` falls first, nothing is written.
- R11: Read data and `err_flag` appear at the second clock edge after the cycle starts. While `cs` stays high, they are refreshed every clock from the current array contents.
- R12: After reset, `data_oe` and `err_flag` are low and every word reads as 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select; a new high level opens a cycle |
| we | input | 1 | Write request, captured when the cycle opens |
| we_async | input | 1 | Write start; a captured write waits for it |
| oe | input | 1 | Output enable for read data |
| inh_lo_n | input | 1 | Write inhibit for the lower half, active low |
| inh_hi_n | input | 1 | Write inhibit for the upper half, active low |
| ecc_bypass | input | 1 | Return raw stored data without correction |
| addr | input | 6 | Word address |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Read data |
| data_oe | output | 1 | High when the block drives read data |
| err_flag | output | 1 | Nonzero syndrome seen on the current read |
| fault_en | input | 1 | Back-door fault strobe |
| fault_addr | input | 6 | Word to corrupt |
| fault_pos | input | 5 | Codeword position (1..21) to flip; 0 does nothing |

## Verification
A wrong codeword layout or a mis-built syndrome shows up at the second clock edge of a read as a wrong `data_out` or a wrong `err_flag`. The bench injects faults at data and check positions so that each parity group is covered. A correction that leaked back into the array would show as a clean re-read of a word that should still flag, one cycle later. A latch that failed to hold, or a guard that decoded the wrong half, shows only on the next read of the affected word. The bench therefore follows every blocked or ignored write with a read of that address and of a neighbour in the other half.

// File: rtl/hg_pkg.sv
package hg_pkg;

   typedef logic [63:0] hg_vec_t;

   // number of check bits needed for dw data bits
   function automatic int hg_check_bits(int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   function automatic bit hg_is_pow2(int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // positions (1-based) covered by check bit k
   function automatic hg_vec_t hg_cover_mask(int k, int cw);
      hg_vec_t m;
      m = '0;
      for (int p = 1; p <= cw; p++)
         if ((p >> k) & 1) m[p-1] = 1'b1;
      return m;
   endfunction

   // syndrome as XOR of set positions; zero for a clean codeword
   function automatic int hg_syndrome(hg_vec_t c, int cw);
      int s;
      s = 0;
      for (int p = 1; p <= cw; p++)
         if (c[p-1]) s = s ^ p;
      return s;
   endfunction

endpackage

// File: rtl/hg_encoder.sv
module hg_encoder
   import hg_pkg::*;
#(
   parameter int  DW = 16,
   localparam int PW = hg_check_bits(DW),
   localparam int CW = DW + PW
) (
   input  logic [DW-1:0] data_i,
   output logic [CW-1:0] code_o
);

   logic [CW-1:0] placed;
   logic [PW-1:0] chk;

   // scatter data bits over the non-power-of-two positions
   always_comb begin
      int j;
      placed = '0;
      j = 0;
      for (int p = 1; p <= CW; p++) begin
         if (!hg_is_pow2(p)) begin
            placed[p-1] = data_i[j];
            j++;
         end
      end
   end

   for (genvar gk = 0; gk < PW; gk++) begin : g_chk
      localparam hg_vec_t MASK = hg_cover_mask(gk, CW);
      assign chk[gk] = ^(placed & MASK[CW-1:0]);
   end

   always_comb begin
      code_o = placed;
      for (int k = 0; k < PW; k++) code_o[(1 << k) - 1] = chk[k];
   end

endmodule

// File: rtl/hg_decoder.sv
module hg_decoder
   import hg_pkg::*;
#(
   parameter int  DW = 16,
   localparam int PW = hg_check_bits(DW),
   localparam int CW = DW + PW
) (
   input  logic [CW-1:0] code_i,
   input  logic          bypass_i,
   output logic [DW-1:0] data_o,
   output logic          err_o
);

   logic [PW-1:0] syn;
   logic [CW-1:0] fixed;
   logic [DW-1:0] raw_d;
   logic [DW-1:0] cor_d;

   for (genvar gk = 0; gk < PW; gk++) begin : g_syn
      localparam hg_vec_t MASK = hg_cover_mask(gk, CW);
      assign syn[gk] = ^(code_i & MASK[CW-1:0]);
   end

   // flip the pointed position; out-of-range syndromes leave the word alone
   always_comb begin
      fixed = code_i;
      if ((syn != '0) && (int'(syn) <= CW))
         fixed[int'(syn) - 1] = ~code_i[int'(syn) - 1];
   end

   always_comb begin
      int j;
      raw_d = '0;
      cor_d = '0;
      j = 0;
      for (int p = 1; p <= CW; p++) begin
         if (!hg_is_pow2(p)) begin
            raw_d[j] = code_i[p-1];
            cor_d[j] = fixed[p-1];
            j++;
         end
      end
   end

   assign data_o = bypass_i ? raw_d : cor_d;
   assign err_o  = |syn;

endmodule

// File: rtl/hg_array.sv
module hg_array #(
   parameter int AW             = 6,
   parameter int CW             = 21,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH = 1 << AW,
   localparam int FPW   = $clog2(CW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [CW-1:0]  wr_code,
   input  logic [AW-1:0]  rd_addr,
   output logic [CW-1:0]  rd_code,
   input  logic           flt_en,
   input  logic [AW-1:0]  flt_addr,
   input  logic [FPW-1:0] flt_pos
);

   logic [CW-1:0] mem [DEPTH];
   logic          flt_ok;

   assign flt_ok  = flt_en && (flt_pos != '0) && (int'(flt_pos) <= CW);
   assign rd_code = mem[rd_addr];

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else begin
            if (wr_en) mem[wr_addr] <= wr_code;
            if (flt_ok) mem[flt_addr][int'(flt_pos) - 1] <= ~mem[flt_addr][int'(flt_pos) - 1];
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_addr] <= wr_code;
         if (flt_ok) mem[flt_addr][int'(flt_pos) - 1] <= ~mem[flt_addr][int'(flt_pos) - 1];
      end
   end

   // stored words change only by write or injected fault
   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !flt_en) |=> (($past(rd_addr) != rd_addr) || (rd_code == $past(rd_code)))); // R4

endmodule

// File: rtl/hg_region_guard.sv
module hg_region_guard #(
   parameter int  REGIONS = 2,
   localparam int RB = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
   input  logic [RB-1:0]      region_i,
   input  logic [REGIONS-1:0] inh_n_i,
   output logic               permit_o
);

   if (REGIONS == 1) begin : g_single
      logic unused_region;
      assign unused_region = ^region_i;
      assign permit_o      = inh_n_i[0];
   end else begin : g_split
      assign permit_o = inh_n_i[region_i];
   end

endmodule

// File: rtl/hg_cycle_ctrl.sv
module hg_cycle_ctrl #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic          we_async,
   output logic [AW-1:0] lat_addr,
   output logic          lat_we,
   output logic          wr_fire,
   output logic          rd_en
);

   logic cs_q;
   logic act;
   logic pend;
   logic start;

   assign start   = cs && !cs_q;
   assign wr_fire = cs && act && pend && we_async;
   assign rd_en   = cs && act && !lat_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b0;
         act      <= 1'b0;
         pend     <= 1'b0;
         lat_we   <= 1'b0;
         lat_addr <= '0;
      end else begin
         cs_q <= cs;
         if (!cs) begin
            act  <= 1'b0;
            pend <= 1'b0;
         end else if (start) begin
            act      <= 1'b1;
            pend     <= we;
            lat_we   <= we;
            lat_addr <= addr;
         end else if (wr_fire) begin
            pend <= 1'b0;
         end
      end
   end

   AST_ONE_WRITE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_fire); // R10

   AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && $past(cs) && $past(act)) |-> ($stable(lat_addr) && $stable(lat_we))); // R6

endmodule

// File: rtl/hamming_guarded_ram.sv
module hamming_guarded_ram
   import hg_pkg::*;
#(
   parameter int  AW             = 6,
   parameter int  DW             = 16,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int PW  = hg_check_bits(DW),
   localparam int CW  = DW + PW,
   localparam int FPW = $clog2(CW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs,
   input  logic           we,
   input  logic           we_async,
   input  logic           oe,
   input  logic           inh_lo_n,
   input  logic           inh_hi_n,
   input  logic           ecc_bypass,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  data_in,
   output logic [DW-1:0]  data_out,
   output logic           data_oe,
   output logic           err_flag,
   input  logic           fault_en,
   input  logic [AW-1:0]  fault_addr,
   input  logic [FPW-1:0] fault_pos
);

   localparam int REGIONS = 2;

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("hamming_guarded_ram: AW out of range");
   end
   if (DW < 4 || DW > 57) begin : g_bad_dw
      $error("hamming_guarded_ram: DW out of range");
   end

   logic [AW-1:0] lat_addr;
   logic          lat_we;
   logic          wr_fire;
   logic          rd_en;
   logic          permit;
   logic          arr_we;
   logic [CW-1:0] wr_code;
   logic [CW-1:0] rd_code;
   logic [DW-1:0] dec_data;
   logic          dec_err;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          rd_err;

   hg_cycle_ctrl #(.AW(AW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (cs),
      .addr     (addr),
      .we       (we),
      .we_async (we_async),
      .lat_addr (lat_addr),
      .lat_we   (lat_we),
      .wr_fire  (wr_fire),
      .rd_en    (rd_en)
   );

   hg_region_guard #(.REGIONS(REGIONS)) u_guard (
      .region_i (lat_addr[AW-1]),
      .inh_n_i  ({inh_hi_n, inh_lo_n}),
      .permit_o (permit)
   );

   assign arr_we = wr_fire && permit;

   hg_encoder #(.DW(DW)) u_enc (
      .data_i (data_in),
      .code_o (wr_code)
   );

   hg_array #(.AW(AW), .CW(CW), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (arr_we),
      .wr_addr  (lat_addr),
      .wr_code  (wr_code),
      .rd_addr  (lat_addr),
      .rd_code  (rd_code),
      .flt_en   (fault_en),
      .flt_addr (fault_addr),
      .flt_pos  (fault_pos)
   );

   hg_decoder #(.DW(DW)) u_dec (
      .code_i   (rd_code),
      .bypass_i (ecc_bypass),
      .data_o   (dec_data),
      .err_o    (dec_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_err   <= 1'b0;
      end else if (!cs) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_err   <= 1'b0;
      end else if (rd_en) begin
         rd_valid <= 1'b1;
         rd_data  <= dec_data;
         rd_err   <= dec_err;
      end
   end

   assign data_out = rd_data;
   assign data_oe  = cs && oe && rd_valid;
   assign err_flag = rd_valid && rd_err;

   AST_NO_DRIVE_IN_WRITE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> !lat_we); // R9

   AST_STORE_IS_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (hg_syndrome(hg_vec_t'(wr_code), CW) == 0)); // R1

   AST_FLAG_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> !lat_we); // R2

   AST_INHIBITED_HALF_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (lat_addr[AW-1] ? inh_hi_n : inh_lo_n)); // R7

endmodule

// File: tb/tb_hamming_guarded_ram.sv
module tb_hamming_guarded_ram;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs, we, we_async, oe, inh_lo_n, inh_hi_n, ecc_bypass;
   logic [5:0]  addr;
   logic [15:0] data_in;
   logic [15:0] data_out;
   logic        data_oe, err_flag;
   logic        fault_en;
   logic [5:0]  fault_addr;
   logic [4:0]  fault_pos;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   hamming_guarded_ram dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .we_async(we_async), .oe(oe),
      .inh_lo_n(inh_lo_n), .inh_hi_n(inh_hi_n), .ecc_bypass(ecc_bypass),
      .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
      .err_flag(err_flag), .fault_en(fault_en), .fault_addr(fault_addr),
      .fault_pos(fault_pos)
   );

   // fields: addr, data, fault position, bypass, expected data, expected flag
   localparam logic [44:0] VEC [8] = '{
      {6'd3,  16'hA5C3, 5'd0,  1'b0, 16'hA5C3, 1'b0},
      {6'd5,  16'h1234, 5'd3,  1'b0, 16'h1234, 1'b1},
      {6'd40, 16'hFFFF, 5'd21, 1'b0, 16'hFFFF, 1'b1},
      {6'd63, 16'h0F0F, 5'd16, 1'b0, 16'h0F0F, 1'b1},
      {6'd10, 16'h8001, 5'd12, 1'b1, 16'h8081, 1'b1},
      {6'd33, 16'h5555, 5'd1,  1'b0, 16'h5555, 1'b1},
      {6'd20, 16'h0000, 5'd7,  1'b0, 16'h0000, 1'b1},
      {6'd50, 16'hBEEF, 5'd0,  1'b1, 16'hBEEF, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk); cs = 1; we = 1; we_async = 1; addr = a; data_in = d;
      @(negedge clk);
      @(negedge clk); cs = 0; we = 0; we_async = 0;
      @(negedge clk);
   endtask

   task automatic do_read(input logic [5:0] a, input logic byp,
                          output logic [15:0] d, output logic e);
      @(negedge clk); cs = 1; we = 0; oe = 1; addr = a; ecc_bypass = byp;
      @(negedge clk);
      @(negedge clk); d = data_out; e = err_flag;
      cs = 0; ecc_bypass = 0;
      @(negedge clk);
   endtask

   task automatic inject(input logic [5:0] a, input logic [4:0] p);
      @(negedge clk); fault_en = 1; fault_addr = a; fault_pos = p;
      @(negedge clk); fault_en = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic        e;
      rst_n = 0; cs = 0; we = 0; we_async = 0; oe = 0; inh_lo_n = 1; inh_hi_n = 1;
      ecc_bypass = 0; addr = '0; data_in = '0; fault_en = 0; fault_addr = '0; fault_pos = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R12 oe after reset", 32'(data_oe), 32'd0);
      chk("R12 flag after reset", 32'(err_flag), 32'd0);
      do_read(6'd0, 1'b0, d, e);
      chk("R12 cleared word", 32'(d), 32'h0);
      chk("R12 cleared flag", 32'(e), 32'd0);

      // table walk: R1 R2 R3 R5
      for (int i = 0; i < 8; i++) begin
         logic [44:0] v;
         v = VEC[i];
         do_write(v[44:39], v[38:23]);
         if (v[22:18] != 0) inject(v[44:39], v[22:18]);
         do_read(v[44:39], v[17], d, e);
         chk($sformatf("R2 R3 R5 R1 data vec%0d", i), 32'(d), 32'(v[16:1]));
         chk($sformatf("R2 R3 R5 flag vec%0d", i), 32'(e), 32'(v[0]));
      end

      // R4: no write-back
      do_write(6'd7, 16'h3C3C);
      inject(6'd7, 5'd6);
      do_read(6'd7, 1'b0, d, e);
      chk("R4 first read data", 32'(d), 32'h3C3C);
      do_read(6'd7, 1'b0, d, e);
      chk("R4 reread still flags", 32'(e), 32'd1);
      do_read(6'd7, 1'b1, d, e);
      chk("R4 R5 raw still faulty", 32'(d), 32'h3C38);
      do_write(6'd7, 16'h1111);
      do_read(6'd7, 1'b0, d, e);
      chk("R4 rewrite clean flag", 32'(e), 32'd0);
      chk("R4 rewrite data", 32'(d), 32'h1111);

      // R6 and R11 and R9: latched read ignores later addr/we changes
      @(negedge clk); cs = 1; we = 0; oe = 1; addr = 6'd3;
      @(negedge clk);
      chk("R11 not valid after first edge", 32'(data_oe), 32'd0);
      addr = 6'd40; we = 1; we_async = 1; data_in = 16'hDEAD;
      @(negedge clk);
      chk("R6 latched address data", 32'(data_out), 32'hA5C3);
      chk("R9 R11 drives on read", 32'(data_oe), 32'd1);
      oe = 0;
      #1 chk("R9 oe low floats", 32'(data_oe), 32'd0);
      @(negedge clk); cs = 0; we = 0; we_async = 0; oe = 1;
      @(negedge clk);
      chk("R9 deselected floats", 32'(data_oe), 32'd0);
      do_read(6'd40, 1'b0, d, e);
      chk("R6 read cycle did not write", 32'(d), 32'hFFFF);

      // R10: write waits for we_async
      @(negedge clk); cs = 1; we = 1; we_async = 0; addr = 6'd12; data_in = 16'h0001;
      @(negedge clk);
      @(negedge clk);
      chk("R9 no drive in write cycle", 32'(data_oe), 32'd0);
      @(negedge clk); cs = 0; we = 0;
      @(negedge clk);
      do_read(6'd12, 1'b0, d, e);
      chk("R10 no write without start", 32'(d), 32'h0000);
      @(negedge clk); cs = 1; we = 1; we_async = 0; addr = 6'd12; data_in = 16'h0001;
      @(negedge clk);
      @(negedge clk); we_async = 1; data_in = 16'hCAFE;
      @(negedge clk); cs = 0; we = 0; we_async = 0; data_in = 16'h0002;
      @(negedge clk);
      do_read(6'd12, 1'b0, d, e);
      chk("R10 delayed write data", 32'(d), 32'hCAFE);

      // R11: held read refreshes from array
      @(negedge clk); cs = 1; we = 0; oe = 1; addr = 6'd12;
      @(negedge clk);
      @(negedge clk);
      chk("R11 held read clean", 32'(err_flag), 32'd0);
      fault_en = 1; fault_addr = 6'd12; fault_pos = 5'd9;
      @(negedge clk); fault_en = 0;
      @(negedge clk);
      chk("R11 held read sees fault", 32'(err_flag), 32'd1);
      chk("R11 R2 held read corrected", 32'(data_out), 32'hCAFE);
      cs = 0;
      @(negedge clk);

      // R7 R8: independent inhibits
      inh_lo_n = 0;
      do_write(6'd3, 16'hDEAD);
      do_read(6'd3, 1'b0, d, e);
      chk("R7 lower write dropped", 32'(d), 32'hA5C3);
      do_write(6'd63, 16'h7777);
      do_read(6'd63, 1'b0, d, e);
      chk("R8 upper writable while lower inhibited", 32'(d), 32'h7777);
      inh_lo_n = 1; inh_hi_n = 0;
      do_write(6'd63, 16'h9999);
      do_read(6'd63, 1'b0, d, e);
      chk("R8 upper write dropped", 32'(d), 32'h7777);
      do_write(6'd3, 16'h4242);
      do_read(6'd3, 1'b0, d, e);
      chk("R7 lower writable when permitted", 32'(d), 32'h4242);
      inh_hi_n = 1;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule